// File: doc/BRIEF.md
# Fractional Clock-Enable Rate Controller

This block thins a fast clock into a clock-enable stream whose average rate is a programmable fraction m/32 of the input clock. The input runs in 32-cycle frames. In each frame the block passes m cycles and swallows the rest. The passed cycles are spread evenly by a phase accumulator, so the enables are not bunched at the start of the frame. Downstream logic gates its registers with the enable and so runs at the derived rate.

Software writes the rate as a 5-bit code equal to 32 minus m. A code of zero therefore means full rate. The code sits in a pending register and does nothing until software sets a commit flag in a second register. The controller then waits for the current frame to end. It loads the new multiplier on the first cycle of the next frame and drops the commit flag on that same edge. While the flag is up, the block reports itself busy and refuses new rate codes.

The controller is a two-state machine:
- ST_IDLE moves to ST_PENDING on a commit write.
- ST_PENDING moves back to ST_IDLE on the last cycle of a frame. That transition loads the multiplier.

Top module: `frac_rate_ctl`

## Requirements
- R1: A write with `wr_sel`=0 stores `wr_data[12:8]` as the rate code. Reading with `rd_sel`=0 returns the code in bits 12:8 and zero in every other bit.
- R2: After reset the rate code is 0, the multiplier is 32 (`clk_en_out` high on every cycle), and the commit flag and `busy` are 0.
- R3: Every 32-cycle frame contains exactly m enable cycles, where m = 32 minus the applied code (range 1 to 32).
- R4: In frame cycle k (0 to 31), `clk_en_out` is 1 exactly when floor((k+1)·m/32) > floor(k·m/32).
- R5: A rate code changes nothing at the output until it is committed. A commit is a write with `wr_sel`=1 and `wr_data[31]`=1. A write with `wr_sel`=1 and bit 31 clear has no effect.
- R6: A committed code takes effect on the first cycle of the frame after the commit was accepted, never in the middle of a frame. The commit flag clears on that same clock edge.
- R7: The commit flag reads back as bit 31 when `rd_sel`=1 and drives `busy`. It stays 1 for the whole time a commit is pending, which is never more than 32 cycles.
- R8: Rate-code writes made while `busy` is 1 are ignored. The pending code is kept unchanged.
- R9: Reading with `rd_sel`=1 returns zero in bits 30:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being thinned |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = rate register, 1 = commit register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 = rate register, 1 = commit register |
| rd_data | output | 32 | Combinational read data |
| clk_en_out | output | 1 | Derived clock-enable stream |
| busy | output | 1 | Commit pending |

## Verification
Suppose the frame counter has drifted, or the multiplier was loaded in mid-frame. The enable pattern then stops matching the arithmetic pulse rule within one frame, and the per-frame enable count is wrong by the end of that frame. A phase accumulator that fails to return to zero shows up as a wrongly placed enable within a few cycles. A stuck or early-cleared commit flag shows up on `busy` and in the bit-31 readback on the first cycle it differs, or at the latest 32 cycles after a commit. The bench sweeps all 32 codes and compares every cycle against a frame model that computes the pulse rule arithmetically.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;

    // Commit sequencer states
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } seq_state_t;

endpackage

// File: rtl/frac_rate_regs.sv
module frac_rate_regs #(
    parameter int DATA_W     = 32,
    parameter int FRAME_BITS = 5,
    parameter int FIELD_LSB  = 8,
    parameter int KICK_BIT   = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  code_wr,
    input  logic [FRAME_BITS-1:0] code_wdata,
    input  logic                  rd_sel,
    input  logic                  busy,
    output logic [FRAME_BITS-1:0] code_q,
    output logic [DATA_W-1:0]     rd_data
);

    // Pending rate code; frozen while a commit is outstanding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (code_wr && !busy) begin
            code_q <= code_wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_sel) begin
            rd_data[FIELD_LSB +: FRAME_BITS] = code_q;
        end else begin
            rd_data[KICK_BIT] = busy;
        end
    end

endmodule

// File: rtl/frac_rate_seq.sv
module frac_rate_seq
    import frac_rate_pkg::*;
#(
    parameter int FRAME_BITS = 5,
    localparam int FRAME     = 1 << FRAME_BITS,
    localparam int MW        = FRAME_BITS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_req,
    input  logic [FRAME_BITS-1:0] code,
    output logic                  busy,
    output logic                  frame_last,
    output logic [FRAME_BITS-1:0] frame_cnt,
    output logic [MW-1:0]         mult_act
);

    localparam logic [MW-1:0]         FRAME_M = MW'(FRAME);
    localparam logic [FRAME_BITS-1:0] LAST_C  = FRAME_BITS'(FRAME - 1);

    seq_state_t state_q, state_d;
    logic       load;

    assign frame_last = (frame_cnt == LAST_C);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (commit_req) state_d = ST_PENDING;
            ST_PENDING: if (frame_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs of the state machine
    always_comb begin
        busy = 1'b0;
        load = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_PENDING: begin
                busy = 1'b1;
                load = frame_last;
            end
            default:    busy = 1'b0;
        endcase
    end

    // Free-running frame position and applied multiplier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            mult_act  <= FRAME_M;
        end else begin
            frame_cnt <= frame_cnt + 1'b1;
            if (load) mult_act <= FRAME_M - {1'b0, code};
        end
    end

endmodule

// File: rtl/frac_rate_accum.sv
module frac_rate_accum #(
    parameter int FRAME_BITS = 5,
    localparam int FRAME     = 1 << FRAME_BITS,
    localparam int MW        = FRAME_BITS + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mult,
    input  logic          frame_last,
    output logic          en
);

    logic [MW-1:0] acc_q;
    logic [MW:0]   sum;
    logic [MW:0]   wrap;

    assign sum  = {1'b0, acc_q} + {1'b0, mult};
    assign en   = (sum >= (MW+1)'(FRAME));
    assign wrap = sum - (MW+1)'(FRAME);

    // Phase accumulator; restarts at zero on every frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (frame_last) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= wrap[MW-1:0];
        end else begin
            acc_q <= sum[MW-1:0];
        end
    end

endmodule

// File: rtl/frac_rate_ctl.sv
module frac_rate_ctl #(
    parameter int DATA_W     = 32,
    parameter int FRAME_BITS = 5,
    parameter int FIELD_LSB  = 8,
    parameter int KICK_BIT   = 31,
    localparam int MW        = FRAME_BITS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_en_out,
    output logic              busy
);

    logic [FRAME_BITS-1:0] code_q;
    logic [FRAME_BITS-1:0] frame_cnt;
    logic [MW-1:0]         mult_act;
    logic                  frame_last;
    logic                  code_wr;
    logic                  commit_req;
    logic                  wr_data_unused;

    assign code_wr        = wr_en && !wr_sel;
    assign commit_req     = wr_en && wr_sel && wr_data[KICK_BIT];
    assign wr_data_unused = ^wr_data;

    frac_rate_regs #(
        .DATA_W     (DATA_W),
        .FRAME_BITS (FRAME_BITS),
        .FIELD_LSB  (FIELD_LSB),
        .KICK_BIT   (KICK_BIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_wr    (code_wr),
        .code_wdata (wr_data[FIELD_LSB +: FRAME_BITS]),
        .rd_sel     (rd_sel),
        .busy       (busy),
        .code_q     (code_q),
        .rd_data    (rd_data)
    );

    frac_rate_seq #(
        .FRAME_BITS (FRAME_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_req (commit_req),
        .code       (code_q),
        .busy       (busy),
        .frame_last (frame_last),
        .frame_cnt  (frame_cnt),
        .mult_act   (mult_act)
    );

    frac_rate_accum #(
        .FRAME_BITS (FRAME_BITS)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .mult       (mult_act),
        .frame_last (frame_last),
        .en         (clk_en_out)
    );

endmodule

// File: rtl/frac_rate_ctl_chk.sv
module frac_rate_ctl_chk #(
    parameter int FRAME_BITS = 5,
    localparam int FRAME     = 1 << FRAME_BITS,
    localparam int MW        = FRAME_BITS + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clk_en_out,
    input logic                  busy,
    input logic [FRAME_BITS-1:0] code_q,
    input logic [FRAME_BITS-1:0] frame_cnt,
    input logic [MW-1:0]         mult_act
);

    logic [MW-1:0] en_cnt;
    logic [MW-1:0] en_total;
    logic [MW-1:0] busy_len;

    assign en_total = en_cnt + MW'(clk_en_out);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_cnt   <= '0;
            busy_len <= '0;
        end else begin
            en_cnt   <= (frame_cnt == FRAME_BITS'(FRAME - 1)) ? '0 : en_total;
            busy_len <= busy ? busy_len + 1'b1 : '0;
        end
    end

    AST_FRAME_ENABLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt == FRAME_BITS'(FRAME - 1)) |-> (en_total == mult_act)); // R3

    AST_MULT_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != '0) |-> $stable(mult_act)); // R6

    AST_COMMIT_CLEARS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (frame_cnt == '0)); // R6

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < MW'(FRAME))); // R7

    AST_CODE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(code_q)); // R8

    AST_MULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_act != '0) && (mult_act <= MW'(FRAME))); // R3

endmodule

bind frac_rate_ctl frac_rate_ctl_chk #(
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_out (clk_en_out),
    .busy       (busy),
    .code_q     (code_q),
    .frame_cnt  (frame_cnt),
    .mult_act   (mult_act)
);

// File: tb/frac_rate_ctl_test.sv
module frac_rate_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        clk_en_out;
    logic        busy;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    frac_rate_ctl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .clk_en_out (clk_en_out),
        .busy       (busy)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Frame model built from the requirements
    logic [4:0] m_k;        // frame position
    int         m_mult;     // applied multiplier
    logic [4:0] m_code;     // pending code
    logic       m_kick;     // commit flag
    int         en_seen;
    int         busy_run;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_k <= '0; m_mult <= 32; m_code <= '0; m_kick <= 1'b0;
        end else begin
            m_k <= m_k + 1'b1;
            if (wr_en && !wr_sel && !m_kick) m_code <= wr_data[12:8];
            if (m_kick && m_k == 5'd31) begin
                m_mult <= 32 - int'(m_code);
                m_kick <= 1'b0;
            end else if (wr_en && wr_sel && wr_data[31]) begin
                m_kick <= 1'b1;
            end
        end
    end

    always @(posedge clk) rd_sel <= ~rd_sel;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    function automatic logic pulse_rule(input int k, input int m);
        return (((k + 1) * m) / 32) != ((k * m) / 32);
    endfunction

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R2 enable in reset", {31'b0, clk_en_out}, 32'd1);
            chk("R2 busy in reset", {31'b0, busy}, 32'd0);
            chk("R2 readback in reset", rd_data, 32'd0);
            en_seen = 0;
            busy_run = 0;
        end else begin
            chk("R4 enable placement", {31'b0, clk_en_out},
                {31'b0, pulse_rule(int'(m_k), m_mult)});
            chk("R7 busy flag", {31'b0, busy}, {31'b0, m_kick});
            if (rd_sel) chk("R7/R9 commit readback", rd_data, {m_kick, 31'b0});
            else        chk("R1 code readback", rd_data, {19'b0, m_code, 8'b0});
            en_seen += int'(clk_en_out);
            if (m_k == 5'd31) begin
                chk("R3 enables per frame", en_seen, m_mult);
                en_seen = 0;
            end
            if (m_kick) busy_run++;
            else if (busy_run > 0) begin
                chk("R7 busy duration <= 32", {31'b0, busy_run <= 32}, 32'd1);
                busy_run = 0;
            end
        end
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected done", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(40);                                  // R2 full rate after reset
        wr(1'b0, 32'h0000_0500);                   // R5 code without commit
        idle(70);
        wr(1'b1, 32'h7FFF_FFFF);                   // R5 bit 31 clear: no commit
        idle(70);
        for (int f = 0; f < 32; f++) begin
            wr(1'b0, (32'hA5A5_E0F3) | (32'(f) << 8)); // R1 other bits ignored
            wr(1'b1, 32'h8000_1234);               // R6 commit
            if (f % 2 == 1) wr(1'b0, 32'h0000_1F00);   // R8 write while busy
            idle(f % 7);
            wait_idle();
            idle(64);
        end
        wr(1'b1, 32'h8000_0000);                   // R7 recommit same code
        wr(1'b1, 32'h8000_0000);                   // second commit while pending
        wait_idle();
        idle(70);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule